// File: doc/BRIEF.md
# Carry-Lookahead Adder-Subtractor

This block is a purely combinational two's-complement adder and subtractor of parameterised width. Each operand bit pair yields a generate term (both bits set) and a propagate term (either bit set). The word is split into four-bit groups. Inside a group, a flat sum-of-products network forms all four carries at once from the group's incoming carry and its generate and propagate terms. The carry out of one group is the incoming carry of the next. Each sum bit is the exclusive-OR of the two operand bits and the carry into that position.

A single mode input selects between the two operations. In subtract mode, the second operand is inverted before it reaches the generate and propagate stage, and the carry into bit 0 is forced high. The external carry input therefore matters only when adding. The block gives three results: the sum word, the raw carry out of the top bit, and a signed-overflow flag. The overflow flag is the exclusive-OR of the carry into the top bit and the carry out of it. In subtract mode, the carry output is the complement of a borrow.

The width must be a multiple of four. There is no clock and there are no registers. All outputs follow the inputs within the same cycle.

Top module: `cla_addsub`

## Requirements
- R1: With `sub_mode` = 0, `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^WIDTH, with the operands taken as unsigned.
- R2: With `sub_mode` = 0, `carry_out` is 1 exactly when `op_a` + `op_b` + `carry_in` is at least 2^WIDTH.
- R3: With `sub_mode` = 1, `sum` equals (`op_a` − `op_b`) modulo 2^WIDTH, and `carry_in` has no effect on any output.
- R4: With `sub_mode` = 1, `carry_out` is 1 exactly when `op_a` ≥ `op_b` as unsigned numbers, so it is the complement of a borrow.
- R5: `overflow` is 1 exactly when the true signed result falls outside [−2^(WIDTH−1), 2^(WIDTH−1)−1]. The operands are read as two's complement, and the result is `op_a` + `op_b` + `carry_in` when adding and `op_a` − `op_b` when subtracting.
- R6: At WIDTH = 4, 0111 + 0110 gives `sum` = 1101 with `overflow` = 1 and `carry_out` = 0. 0111 − 0110 gives `sum` = 0001 with `overflow` = 0 and `carry_out` = 1.
- R7: At WIDTH = 32, R1 to R5 hold for every pairing of the operands 0, 1, all ones, the most negative value and the most positive value, in both modes and with both carry-in values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| carry_in | input | 1 | Carry into bit 0 when adding; ignored when subtracting |
| sum | output | WIDTH | Result word |
| carry_out | output | 1 | Raw carry out of the most significant bit |
| overflow | output | 1 | Signed-overflow flag |

## Verification
There is no register anywhere in the block, so the sum, the carry and the overflow flag are all due in the same cycle the operands are applied. The bench drives a new vector one time unit after each clock edge. It reads all three outputs two units later, which is still before the next edge, so every result is compared once the gates have settled and never at an edge. The expected values come from whole-number arithmetic in the bench: a wrapped sum, an unsigned comparison for the carry, and a signed range test for overflow. The bench sweeps every input combination at widths 4 and 8, then runs corner operands and random operands at width 32.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Bits handled by one flat lookahead network.
    localparam int CLA_GROUP_BITS = 4;

    // Number of lookahead groups needed to cover a word.
    function automatic int cla_group_count(input int width);
        return (width + CLA_GROUP_BITS - 1) / CLA_GROUP_BITS;
    endfunction

endpackage

// File: rtl/cla_gp_bits.sv
// Per-bit generate and propagate terms.
module cla_gp_bits #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // A carry is produced here whatever arrives from below.
        assign gen[i]  = opa[i] & opb[i];
        // An incoming carry is passed upward.
        assign prop[i] = opa[i] | opb[i];
    end

endmodule

// File: rtl/cla_lookahead4.sv
// Flat two-level carry network for one four-bit group.
// cout[k] is the carry leaving bit k of the group.
module cla_lookahead4 (
    input  logic [3:0] gen,
    input  logic [3:0] prop,
    input  logic       cin,
    output logic [3:0] cout
);

    always_comb begin
        cout[0] = gen[0]
                | (cin & prop[0]);

        cout[1] = gen[1]
                | (gen[0] & prop[1])
                | (cin & prop[0] & prop[1]);

        cout[2] = gen[2]
                | (gen[1] & prop[2])
                | (gen[0] & prop[1] & prop[2])
                | (cin & prop[0] & prop[1] & prop[2]);

        cout[3] = gen[3]
                | (gen[2] & prop[3])
                | (gen[1] & prop[2] & prop[3])
                | (gen[0] & prop[1] & prop[2] & prop[3])
                | (cin & prop[0] & prop[1] & prop[2] & prop[3]);
    end

endmodule

// File: rtl/cla_sum_bits.sv
// Sum bits from operand bits and the carry entering each position.
module cla_sum_bits #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [WIDTH-1:0] cin_bits,
    output logic [WIDTH-1:0] sum
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum[i] = opa[i] ^ opb[i] ^ cin_bits[i];
    end

endmodule

// File: rtl/cla_addsub.sv
// Carry-lookahead adder-subtractor built from chained four-bit groups.
module cla_addsub
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_mode,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow
);

    localparam int NUM_GROUPS = cla_group_count(WIDTH);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    // carry[i] enters bit i; carry[WIDTH] leaves the top bit.
    logic [WIDTH:0]   carry;

    // Subtraction adds the inverted subtrahend plus one.
    assign b_eff    = op_b ^ {WIDTH{sub_mode}};
    assign carry[0] = sub_mode | carry_in;

    cla_gp_bits #(
        .WIDTH (WIDTH)
    ) u_gp (
        .opa  (op_a),
        .opb  (b_eff),
        .gen  (gen),
        .prop (prop)
    );

    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
        localparam int LO = k * CLA_GROUP_BITS;

        cla_lookahead4 u_la (
            .gen  (gen[LO +: CLA_GROUP_BITS]),
            .prop (prop[LO +: CLA_GROUP_BITS]),
            .cin  (carry[LO]),
            .cout (carry[LO + 1 +: CLA_GROUP_BITS])
        );
    end

    cla_sum_bits #(
        .WIDTH (WIDTH)
    ) u_sum (
        .opa      (op_a),
        .opb      (b_eff),
        .cin_bits (carry[WIDTH-1:0]),
        .sum      (sum)
    );

    assign carry_out = carry[WIDTH];
    // Signed overflow: the carries into and out of the sign bit disagree.
    assign overflow  = carry[WIDTH] ^ carry[WIDTH-1];

endmodule

// File: rtl/cla_addsub_chk.sv
// Arithmetic checker attached to every cla_addsub instance.
module cla_addsub_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub_mode,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out,
    input logic             overflow
);

    logic [WIDTH:0]   add_full;
    logic [WIDTH-1:0] diff_ref;
    logic [WIDTH-1:0] res_ref;
    logic             bsign;
    logic             ovf_ref;

    always_comb begin
        add_full = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        diff_ref = op_a - op_b;
        res_ref  = sub_mode ? diff_ref : add_full[WIDTH-1:0];
        bsign    = op_b[WIDTH-1] ^ sub_mode;
        ovf_ref  = (op_a[WIDTH-1] == bsign) && (res_ref[WIDTH-1] != op_a[WIDTH-1]);

        a_r1_add_sum: assert (sub_mode || sum == add_full[WIDTH-1:0])
            else $error("R1 sum mismatch when adding");
        a_r2_add_carry: assert (sub_mode || carry_out == add_full[WIDTH])
            else $error("R2 carry mismatch when adding");
        a_r3_sub_sum: assert (!sub_mode || sum == diff_ref)
            else $error("R3 difference mismatch");
        a_r4_sub_carry: assert (!sub_mode || carry_out == (op_a >= op_b))
            else $error("R4 carry is not the complement of borrow");
        a_r5_overflow: assert (overflow == ovf_ref)
            else $error("R5 overflow flag mismatch");
    end

endmodule

bind cla_addsub cla_addsub_chk #(
    .WIDTH (WIDTH)
) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_mode  (sub_mode),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .overflow  (overflow)
);

// File: tb/cla_addsub_test.sv
module cla_addsub_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 195000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // Width 8: exhaustive sweep
    logic [7:0]  a8 = '0, b8 = '0, s8;
    logic        sub8 = 1'b0, cin8 = 1'b0, c8, v8;
    // Width 4: worked cases and exhaustive sweep
    logic [3:0]  a4 = '0, b4 = '0, s4;
    logic        sub4 = 1'b0, cin4 = 1'b0, c4, v4;
    // Width 32: corners and random
    logic [31:0] a32 = '0, b32 = '0, s32;
    logic        sub32 = 1'b0, cin32 = 1'b0, c32, v32;

    cla_addsub #(.WIDTH(8)) uut (
        .op_a(a8), .op_b(b8), .sub_mode(sub8), .carry_in(cin8),
        .sum(s8), .carry_out(c8), .overflow(v8)
    );

    cla_addsub #(.WIDTH(4)) uut_nib (
        .op_a(a4), .op_b(b4), .sub_mode(sub4), .carry_in(cin4),
        .sum(s4), .carry_out(c4), .overflow(v4)
    );

    cla_addsub #(.WIDTH(32)) uut_wide (
        .op_a(a32), .op_b(b32), .sub_mode(sub32), .carry_in(cin32),
        .sum(s32), .carry_out(c32), .overflow(v32)
    );

    task automatic model(input int w, input longint unsigned a, input longint unsigned b,
                         input bit sub, input bit cin,
                         output longint unsigned es, output bit ec, output bit ev);
        longint unsigned modv = 64'd1 << w;
        longint unsigned half = modv >> 1;
        longint sa, sb, r;
        sa = (a >= half) ? longint'(a) - longint'(modv) : longint'(a);
        sb = (b >= half) ? longint'(b) - longint'(modv) : longint'(b);
        if (sub) begin
            es = (a + modv - b) % modv;
            ec = (a >= b);
            r  = sa - sb;
        end else begin
            es = (a + b + longint'(cin)) % modv;
            ec = ((a + b + longint'(cin)) >= modv);
            r  = sa + sb + longint'(cin);
        end
        ev = (r > longint'(half) - 1) || (r < -longint'(half));
    endtask

    task automatic check_one(input string grp, input string req,
                             input longint unsigned act, input longint unsigned exp,
                             input longint unsigned a, input longint unsigned b,
                             input bit sub, input bit cin);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: a=%0h b=%0h sub=%0b cin=%0b actual=%0h expected=%0h",
                     grp, req, a, b, sub, cin, act, exp);
        end
    endtask

    task automatic apply(input string grp, input int w,
                         input longint unsigned a, input longint unsigned b,
                         input bit sub, input bit cin);
        longint unsigned es, as;
        bit ec, ev, ac, av;
        @(posedge clk or negedge clk);
        #1;
        case (w)
            4:       begin a4 = a[3:0]; b4 = b[3:0]; sub4 = sub; cin4 = cin; end
            8:       begin a8 = a[7:0]; b8 = b[7:0]; sub8 = sub; cin8 = cin; end
            default: begin a32 = a[31:0]; b32 = b[31:0]; sub32 = sub; cin32 = cin; end
        endcase
        #2;
        case (w)
            4:       begin as = longint'(s4);  ac = c4;  av = v4;  end
            8:       begin as = longint'(s8);  ac = c8;  av = v8;  end
            default: begin as = longint'(s32); ac = c32; av = v32; end
        endcase
        model(w, a, b, sub, cin, es, ec, ev);
        check_one(grp, sub ? "R3 sum" : "R1 sum", as, es, a, b, sub, cin);
        check_one(grp, sub ? "R4 carry" : "R2 carry", longint'(ac), longint'(ec), a, b, sub, cin);
        check_one(grp, "R5 overflow", longint'(av), longint'(ev), a, b, sub, cin);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        longint unsigned corners [5];
        corners[0] = 64'h0;
        corners[1] = 64'h1;
        corners[2] = 64'hFFFF_FFFF;
        corners[3] = 64'h8000_0000;
        corners[4] = 64'h7FFF_FFFF;

        // R1: all-zero operands give zero outputs
        apply("R1 zero", 8, 0, 0, 1'b0, 1'b0);

        // R6: worked cases at width 4
        apply("R6 add", 4, 7, 6, 1'b0, 1'b0);
        check_one("R6", "sum 1101", longint'(s4), 64'hD, 7, 6, 1'b0, 1'b0);
        check_one("R6", "overflow set", longint'(v4), 1, 7, 6, 1'b0, 1'b0);
        check_one("R6", "carry clear", longint'(c4), 0, 7, 6, 1'b0, 1'b0);
        apply("R6 sub", 4, 7, 6, 1'b1, 1'b0);
        check_one("R6", "diff 0001", longint'(s4), 64'h1, 7, 6, 1'b1, 1'b0);
        check_one("R6", "overflow clear", longint'(v4), 0, 7, 6, 1'b1, 1'b0);
        check_one("R6", "carry set", longint'(c4), 1, 7, 6, 1'b1, 1'b0);

        // Exhaustive width 4 (R1..R5, R3 includes carry_in ignored)
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int m = 0; m < 4; m++)
                    apply("w4 sweep", 4, longint'(a), longint'(b), m[1], m[0]);

        // R7: corner pairings at width 32
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int m = 0; m < 4; m++)
                    apply("R7 corners", 32, corners[i], corners[j], m[1], m[0]);

        // Random width 32
        for (int k = 0; k < 400; k++)
            apply("R7 random", 32, longint'($urandom), longint'($urandom),
                  k[0], k[1]);

        // Exhaustive width 8 (R1..R5)
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                for (int m = 0; m < 4; m++)
                    apply("w8 sweep", 8, longint'(a), longint'(b), m[1], m[0]);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule